// File: doc/BRIEF.md
# SPI Response Stream Scanner

This block sits on the master side of an SPI link. It watches the bytes that come back from a slave device and finds the framing bytes in them. The slave may put a variable number of filler bytes in front of the framing byte, so the scanner cannot expect the frame at a fixed position. A transaction begins with a one-cycle `start_i` pulse, and `mode_i` picks one of two scan modes. Any scan already running is dropped at that point.

In data-start mode the scanner skips bytes until one has `0xF` in its upper nibble. It then captures the next `PAYLOAD_BYTES` bytes as the payload. Skipped bytes are counted against a runtime limit: a small value fits short register reads, and a value near one hundred fits the long poll that comes before a block read. If the limit is reached before the tag appears, the transaction ends with a missing-tag error.

In acknowledge mode the scanner collects a `ACK_WIN`-byte window and searches it for the last response-start byte, one with `0xC` in its upper nibble. It then checks that this byte reports the last packet and that the byte after it carries a clean status. The result is a one-cycle `done_o` pulse together with error flags. The flags hold until the next start.

Top module: `rsp_scan_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_no_tag_o`, `err_type_o` and `err_status_o` are 0 and `payload_o` is 0.
- R2: A `start_i` pulse clears all error flags, sets `busy_o` in the next cycle and restarts the scan in the mode given by `mode_i` (0 = data-start, 1 = acknowledge). This holds even when a scan is in progress. A byte presented in the same cycle as `start_i` is ignored.
- R3: In data-start mode, every accepted byte whose bits [7:4] are not 4'hF is skipped as filler. The first byte whose bits [7:4] are 4'hF is the tag, and the tag is not part of the payload.
- R4: After the tag, the next `PAYLOAD_BYTES` accepted bytes form the payload. The first of them lands in the most significant byte of `payload_o`. `done_o` pulses in the cycle after the last payload byte, with `busy_o` low and no error flag. `payload_o` changes only in a cycle where `done_o` is 1.
- R5: In data-start mode, when the number of skipped filler bytes reaches `limit_i` (a limit of 0 acts as 1) and no tag has been seen, `done_o` pulses with `err_no_tag_o` = 1 and `payload_o` keeps its old value.
- R6: In acknowledge mode, `ACK_WIN` accepted bytes (index 0 first) form the window. Among indices 0 to `ACK_WIN`-2, the highest index whose bits [7:4] are 4'hC is selected. If that byte has bits [3:0] = 4'h3 (last packet) and the byte after it is 8'h00, `done_o` pulses with no error flag.
- R7: If no byte at indices 0 to `ACK_WIN`-2 has bits [7:4] = 4'hC, the window ends with `err_no_tag_o` = 1. A start nibble at the final index is not considered.
- R8: If the selected byte's type is not 4'h3, `err_type_o` is set. If the byte after it is not 8'h00, `err_status_o` is set. Both may be set together, and neither is set with `err_no_tag_o`.
- R9: Cycles with `rx_valid_i` low do not advance the scan. Bytes presented while the scanner is idle are ignored.
- R10: `done_o` is a single-cycle pulse. Error flags and `payload_o` hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a new scan |
| mode_i | input | 1 | Scan mode, sampled with start: 0 data-start, 1 acknowledge |
| limit_i | input | LIMIT_W | Filler byte limit for data-start mode, held stable during a scan |
| rx_valid_i | input | 1 | A received byte is present on `rx_byte_i` |
| rx_byte_i | input | 8 | Received byte |
| busy_o | output | 1 | A scan is in progress |
| done_o | output | 1 | One-cycle pulse when a scan ends |
| payload_o | output | PAYLOAD_BYTES*8 | Captured payload, first byte most significant |
| err_no_tag_o | output | 1 | No tag or start byte was found |
| err_type_o | output | 1 | The selected response byte was not a last-packet type |
| err_status_o | output | 1 | The status byte after the selected response byte was not zero |

## Verification
The hardest situation to reach is an acknowledge window that holds more than one response-start byte, where a good early response would hide a bad later one if the search ran in the wrong direction. The stimulus therefore builds windows in which the first and the third byte are both start bytes with different types, and a window whose only start nibble sits at the excluded final index. The other hard points are a byte that arrives in the same cycle as a restart and a filler count that lands exactly on the limit. The bench drives both with a restart during a scan and with limits of 0, 1 and 3.

// File: rtl/rsp_scan_pkg.sv
package rsp_scan_pkg;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_HUNT = 2'd1,
    SC_CAPT = 2'd2,
    SC_ACKW = 2'd3
  } scan_state_e;

  localparam logic [3:0] DATA_TAG_NIB  = 4'hF;
  localparam logic [3:0] RSP_START_NIB = 4'hC;
  localparam logic [3:0] RSP_TYPE_LAST = 4'h3;
  localparam logic [7:0] RSP_STATUS_OK = 8'h00;

  function automatic logic is_data_tag(input logic [7:0] b);
    return b[7:4] == DATA_TAG_NIB;
  endfunction

  function automatic logic is_rsp_start(input logic [7:0] b);
    return b[7:4] == RSP_START_NIB;
  endfunction

  function automatic logic [3:0] rsp_type(input logic [7:0] b);
    return b[3:0];
  endfunction

endpackage

// File: rtl/rsp_fill_counter.sv
module rsp_fill_counter #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [LIMIT_W-1:0] limit,
  output logic               at_limit
);

  logic [LIMIT_W-1:0] cnt_q;
  logic [LIMIT_W:0]   eff_limit;
  logic [LIMIT_W:0]   cnt_inc;

  assign eff_limit = (limit == '0) ? (LIMIT_W+1)'(1) : {1'b0, limit};
  assign cnt_inc   = {1'b0, cnt_q} + (LIMIT_W+1)'(1);
  assign at_limit  = step && (cnt_inc >= eff_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  // R5: a counted filler byte never finds the count already past the limit
  p_step_below_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ({1'b0, cnt_q} < eff_limit));

endmodule

// File: rtl/rsp_byte_shift.sv
module rsp_byte_shift #(
  parameter int NBYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                shift,
  input  logic [7:0]          din,
  output logic [NBYTES*8-1:0] vec_q,
  output logic [NBYTES*8-1:0] vec_nxt
);

  generate
    if (NBYTES == 1) begin : g_single
      assign vec_nxt = din;
    end else begin : g_multi
      assign vec_nxt = {vec_q[NBYTES*8-9:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_q <= '0;
    else if (clear) vec_q <= '0;
    else if (shift) vec_q <= vec_nxt;
  end

endmodule

// File: rtl/rsp_ack_judge.sv
module rsp_ack_judge
  import rsp_scan_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic [WIN*8-1:0] win,
  output logic             found,
  output logic             type_bad,
  output logic             status_bad
);

  logic [7:0] sel_b;
  logic [7:0] next_b;

  // index 0 sits in the top byte; later hits overwrite, so the last one wins
  always_comb begin
    found  = 1'b0;
    sel_b  = '0;
    next_b = '0;
    for (int i = 0; i < WIN-1; i++) begin
      if (is_rsp_start(win[(WIN-1-i)*8 +: 8])) begin
        found  = 1'b1;
        sel_b  = win[(WIN-1-i)*8 +: 8];
        next_b = win[(WIN-2-i)*8 +: 8];
      end
    end
  end

  assign type_bad   = found && (rsp_type(sel_b) != RSP_TYPE_LAST);
  assign status_bad = found && (next_b != RSP_STATUS_OK);

endmodule

// File: rtl/rsp_scan_top.sv
module rsp_scan_top
  import rsp_scan_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4,
  parameter int ACK_WIN       = 4,
  parameter int LIMIT_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       mode_i,
  input  logic [LIMIT_W-1:0]         limit_i,
  input  logic                       rx_valid_i,
  input  logic [7:0]                 rx_byte_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [PAYLOAD_BYTES*8-1:0] payload_o,
  output logic                       err_no_tag_o,
  output logic                       err_type_o,
  output logic                       err_status_o
);

  localparam int POS_MAX = (PAYLOAD_BYTES > ACK_WIN) ? PAYLOAD_BYTES : ACK_WIN;
  localparam int POS_W   = $clog2(POS_MAX) + 1;
  localparam logic [POS_W-1:0] CAP_LAST = POS_W'(PAYLOAD_BYTES - 1);
  localparam logic [POS_W-1:0] ACK_LAST = POS_W'(ACK_WIN - 1);

  scan_state_e st_q;
  logic [POS_W-1:0] pos_q;

  // named internal events
  logic acc_byte;
  logic ev_tag;
  logic ev_fill;
  logic ev_timeout;
  logic ev_cap_last;
  logic ev_ack_full;

  logic [PAYLOAD_BYTES*8-1:0] cap_q, cap_nxt;
  logic [ACK_WIN*8-1:0]       ack_q, ack_nxt;
  logic ack_found, ack_type_bad, ack_status_bad;

  assign acc_byte    = rx_valid_i && !start_i;
  assign ev_tag      = (st_q == SC_HUNT) && acc_byte && is_data_tag(rx_byte_i);
  assign ev_fill     = (st_q == SC_HUNT) && acc_byte && !is_data_tag(rx_byte_i);
  assign ev_cap_last = (st_q == SC_CAPT) && acc_byte && (pos_q == CAP_LAST);
  assign ev_ack_full = (st_q == SC_ACKW) && acc_byte && (pos_q == ACK_LAST);

  rsp_fill_counter #(.LIMIT_W(LIMIT_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_i),
    .step     (ev_fill),
    .limit    (limit_i),
    .at_limit (ev_timeout)
  );

  rsp_byte_shift #(.NBYTES(PAYLOAD_BYTES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_i),
    .shift   ((st_q == SC_CAPT) && acc_byte),
    .din     (rx_byte_i),
    .vec_q   (cap_q),
    .vec_nxt (cap_nxt)
  );

  rsp_byte_shift #(.NBYTES(ACK_WIN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_i),
    .shift   ((st_q == SC_ACKW) && acc_byte),
    .din     (rx_byte_i),
    .vec_q   (ack_q),
    .vec_nxt (ack_nxt)
  );

  rsp_ack_judge #(.WIN(ACK_WIN)) u_judge (
    .win        (ack_nxt),
    .found      (ack_found),
    .type_bad   (ack_type_bad),
    .status_bad (ack_status_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= SC_IDLE;
      pos_q        <= '0;
      done_o       <= 1'b0;
      payload_o    <= '0;
      err_no_tag_o <= 1'b0;
      err_type_o   <= 1'b0;
      err_status_o <= 1'b0;
    end else if (start_i) begin
      st_q         <= mode_i ? SC_ACKW : SC_HUNT;
      pos_q        <= '0;
      done_o       <= 1'b0;
      err_no_tag_o <= 1'b0;
      err_type_o   <= 1'b0;
      err_status_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SC_HUNT: begin
          if (ev_tag) begin
            st_q  <= SC_CAPT;
            pos_q <= '0;
          end else if (ev_timeout) begin
            st_q         <= SC_IDLE;
            done_o       <= 1'b1;
            err_no_tag_o <= 1'b1;
          end
        end
        SC_CAPT: begin
          if (ev_cap_last) begin
            st_q      <= SC_IDLE;
            done_o    <= 1'b1;
            payload_o <= cap_nxt;
          end else if (acc_byte) begin
            pos_q <= pos_q + 1'b1;
          end
        end
        SC_ACKW: begin
          if (ev_ack_full) begin
            st_q         <= SC_IDLE;
            done_o       <= 1'b1;
            err_no_tag_o <= !ack_found;
            err_type_o   <= ack_type_bad;
            err_status_o <= ack_status_bad;
          end else if (acc_byte) begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (st_q != SC_IDLE);

  // R10: end of scan is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R4: payload only moves together with the done pulse
  p_payload_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(payload_o));
  // R4: the scanner is idle once it reports completion
  p_idle_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R2: a start leaves a busy scanner with clean flags
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && !done_o && !err_no_tag_o && !err_type_o && !err_status_o));
  // R7: a missing start byte excludes the type and status verdicts
  p_notag_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_no_tag_o |-> (!err_type_o && !err_status_o));
  // R5: a new missing-tag error appears only with completion
  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_no_tag_o) |-> done_o);
  // R9: without a start an idle scanner stays idle
  p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: tb/rsp_scan_top_tb_top.sv
`timescale 1ns/1ps
module rsp_scan_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [7:0]  limit = 8'd8;
  logic        valid = 1'b0;
  logic [7:0]  rx = 8'h00;
  logic        busy, done, e_nt, e_ty, e_st;
  logic [31:0] payload;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  rsp_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .limit_i(limit),
    .rx_valid_i(valid), .rx_byte_i(rx), .busy_o(busy), .done_o(done),
    .payload_o(payload), .err_no_tag_o(e_nt), .err_type_o(e_ty), .err_status_o(e_st)
  );

  // behavioural reference model
  int         m_state;   // 0 idle, 1 hunting, 2 capturing, 3 acknowledge window
  int         m_fill;
  logic [7:0] m_q[$];
  logic       m_done, m_nt, m_ty, m_st;
  logic [31:0] m_pay;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_fill = 0; m_q.delete();
      m_done = 0; m_nt = 0; m_ty = 0; m_st = 0; m_pay = 0;
    end else if (start) begin
      m_state = mode ? 3 : 1; m_fill = 0; m_q.delete();
      m_done = 0; m_nt = 0; m_ty = 0; m_st = 0;
    end else begin
      m_done = 0;
      if (valid) begin
        if (m_state == 1) begin
          if (rx[7:4] == 4'hF) begin
            m_state = 2;
          end else begin
            m_fill++;
            if (m_fill >= ((limit == 0) ? 1 : int'(limit))) begin
              m_state = 0; m_done = 1; m_nt = 1;
            end
          end
        end else if (m_state == 2) begin
          m_q.push_back(rx);
          if (m_q.size() == 4) begin
            m_pay = {m_q[0], m_q[1], m_q[2], m_q[3]};
            m_state = 0; m_done = 1;
          end
        end else if (m_state == 3) begin
          m_q.push_back(rx);
          if (m_q.size() == 4) begin
            int sel;
            sel = -1;
            for (int i = 2; i >= 0; i--) begin
              if (sel < 0 && m_q[i][7:4] == 4'hC) sel = i;
            end
            if (sel < 0) m_nt = 1;
            else begin
              m_ty = (m_q[sel][3:0] != 4'h3);
              m_st = (m_q[sel+1] != 8'h00);
            end
            m_state = 0; m_done = 1;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R10 hold behaviour included)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 model busy",    {31'd0, busy}, {31'd0, (m_state != 0)});
      chk("R10 model done",    {31'd0, done}, {31'd0, m_done});
      chk("R10 model no_tag",  {31'd0, e_nt}, {31'd0, m_nt});
      chk("R10 model type",    {31'd0, e_ty}, {31'd0, m_ty});
      chk("R10 model status",  {31'd0, e_st}, {31'd0, m_st});
      chk("R10 model payload", payload, m_pay);
    end
  end

  task automatic drv(input logic s, input logic v, input logic [7:0] b);
    @(negedge clk);
    start = s; valid = v; rx = b;
  endtask

  task automatic go(input logic md, input logic [7:0] lim);
    @(negedge clk);
    mode = md; limit = lim; start = 1'b1; valid = 1'b0; rx = 8'h00;
  endtask

  task automatic put(input logic [7:0] b);
    drv(1'b0, 1'b1, b);
  endtask

  task automatic gap();
    drv(1'b0, 1'b0, 8'h00);
  endtask

  task automatic flags(input string tag, input logic d, input logic nt, input logic ty, input logic st);
    chk({tag, " done"},   {31'd0, done}, {31'd0, d});
    chk({tag, " no_tag"}, {31'd0, e_nt}, {31'd0, nt});
    chk({tag, " type"},   {31'd0, e_ty}, {31'd0, ty});
    chk({tag, " status"}, {31'd0, e_st}, {31'd0, st});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    flags("R1", 0, 0, 0, 0);
    chk("R1 payload", payload, 32'd0);

    // R3 R4: zero and non-zero filler, then tag and payload
    go(1'b0, 8'd8);
    gap();
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    put(8'h00); put(8'h12); put(8'hF3);
    put(8'hAA); put(8'hBB); put(8'hCC); put(8'hDD);
    gap();
    flags("R4 payload done", 1, 0, 0, 0);
    chk("R4 payload value", payload, 32'hAABBCCDD);
    chk("R4 busy low", {31'd0, busy}, 32'd0);
    gap();
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
    chk("R10 payload held", payload, 32'hAABBCCDD);

    // R9: idle bytes ignored, gaps do not advance
    put(8'hF1); put(8'h01); put(8'h02); put(8'h03); put(8'h04); gap();
    chk("R9 idle ignored", payload, 32'hAABBCCDD);
    chk("R9 idle busy", {31'd0, busy}, 32'd0);
    go(1'b0, 8'd4);
    put(8'h00); gap(); gap(); put(8'hF0); gap(); put(8'h11); gap(); put(8'h22);
    put(8'h33); gap(); put(8'h44); gap();
    flags("R9 gaps", 1, 0, 0, 0);
    chk("R9 gap payload", payload, 32'h11223344);

    // R5: limit reached exactly
    go(1'b0, 8'd3);
    put(8'h00); put(8'h00);
    gap();
    chk("R5 below limit busy", {31'd0, busy}, 32'd1);
    put(8'h00); gap();
    flags("R5 timeout", 1, 1, 0, 0);
    chk("R5 payload kept", payload, 32'h11223344);
    // R5: limit 0 acts as 1, tag in first byte still accepted
    go(1'b0, 8'd0);
    put(8'hF7); put(8'h01); put(8'h02); put(8'h03); put(8'h04); gap();
    flags("R5 limit0 tag", 1, 0, 0, 0);
    chk("R5 limit0 payload", payload, 32'h01020304);
    go(1'b0, 8'd0);
    put(8'h00); gap();
    flags("R5 limit0 filler", 1, 1, 0, 0);

    // R2: byte coincident with start ignored
    go(1'b0, 8'd1);
    drv(1'b1, 1'b1, 8'hF3);
    put(8'h00); gap();
    flags("R2 start byte ignored", 1, 1, 0, 0);
    // R2: restart mid-scan into acknowledge mode clears error flags
    go(1'b0, 8'd8);
    put(8'h00); put(8'hF3); put(8'h55);
    go(1'b1, 8'd8);
    put(8'hC3); put(8'h00); put(8'h00); put(8'h00); gap();
    flags("R2 restart ack", 1, 0, 0, 0);
    chk("R2 payload untouched", payload, 32'h01020304);

    // R6: last start wins
    go(1'b1, 8'd8);
    put(8'hC1); put(8'h00); put(8'hC3); put(8'h00); gap();
    flags("R6 last start good", 1, 0, 0, 0);
    go(1'b1, 8'd8);
    put(8'h00); put(8'hC3); put(8'h00); put(8'h77); gap();
    flags("R6 index1 good", 1, 0, 0, 0);
    // R8: later start with wrong type hides earlier good one
    go(1'b1, 8'd8);
    put(8'hC3); put(8'h00); put(8'hC1); put(8'h00); gap();
    flags("R8 type bad", 1, 0, 1, 0);
    go(1'b1, 8'd8);
    put(8'hC3); put(8'h05); put(8'h00); put(8'h00); gap();
    flags("R8 status bad", 1, 0, 0, 1);
    go(1'b1, 8'd8);
    put(8'h00); put(8'h00); put(8'hC2); put(8'h09); gap();
    flags("R8 both bad", 1, 0, 1, 1);
    // R7: start nibble only at final index
    go(1'b1, 8'd8);
    put(8'h00); put(8'h00); put(8'h00); put(8'hC3); gap();
    flags("R7 no start", 1, 1, 0, 0);

    // R3: long poll before a block read
    go(1'b0, 8'd100);
    for (int i = 0; i < 90; i++) put(8'h00);
    put(8'hF3); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF); gap();
    flags("R3 long poll", 1, 0, 0, 0);
    chk("R3 long poll payload", payload, 32'hDEADBEEF);

    repeat (3) gap();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule